// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources for a small processor core: two external pins, three timer events, and a serial port event. Each source passes through its own enable bit and a global enable. A per-source priority bit then places it at either the high or the low level. The controller presents one request to the core together with a fixed vector address for the winning source. When several sources compete at the same level, the source with the lower slot number wins. The vector is 0x03 plus eight times that slot.

The core acknowledges a presented request by pulsing `irq_ack`, which marks that request's level as in service. While a low-level handler runs, only high-level requests are presented, so a high-level source can preempt it. While a high-level handler runs, nothing is presented. Pulsing `irq_ret` at the end of a handler closes the innermost active level, and any request that was held back becomes visible again.

Each external pin is active low and has its own trigger mode. In level mode, the request follows the pin directly. In edge mode, a falling edge sets a detect flag that is held until that vector is acknowledged. The serial request merges its receive and transmit flags, and the timer-2 request merges its overflow and external flags. Acknowledgement does not clear any of these merged flags.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0, both detect flags are 0, and neither `svc_hi` nor `svc_lo` is set.
- R2: The slot numbers are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5. While `irq_req` is 1, `irq_vec` equals 0x03 + 8 × (winning slot). While `irq_req` is 0, `irq_vec` is 0.
- R3: Bit i of `src_en` gates slot i. When `glb_en` is 0, no source is presented.
- R4: A source whose bit in `pri_sel` is 1 is at the high level. Any presentable high-level source wins over every low-level source. Within a level, the lowest slot wins.
- R5: The serial slot requests while `ser_rx_done` or `ser_tx_done` is 1. The timer-2 slot requests while `tmr2_ovf` or `tmr2_ext` is 1.
- R6: In edge mode (`ext_edge_mode[k]` = 1), a pin seen high at one clock edge and low at the next sets `ext_flag[k]` after that edge. The flag holds whatever the pin does afterwards. It clears at the edge where that slot's vector is acknowledged. A pin that stays low sets no new flag.
- R7: In level mode, the slot requests combinationally while the pin is low, and `ext_flag[k]` is 0 from the next edge on. Switching a set flag to level mode clears it.
- R8: An `irq_ack` pulse while `irq_req` is 1 sets `svc_hi` or `svc_lo`, according to the winner's level, after that edge. An `irq_ack` pulse while `irq_req` is 0 changes nothing.
- R9: While `svc_lo` is set, only high-level sources are presented. While `svc_hi` is set, no source is presented.
- R10: An `irq_ret` pulse clears `svc_hi` if it is set, and otherwise clears `svc_lo`.
- R11: `irq_req` and `irq_vec` are combinational in the inputs and state. A change in a level-type request shows in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 6 | Per-slot enable |
| glb_en | input | 1 | Global enable |
| pri_sel | input | 6 | Per-slot level, 1 = high |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_edge_mode | input | 2 | 1 = falling-edge trigger, 0 = level trigger |
| tmr0_ovf | input | 1 | Timer 0 event |
| tmr1_ovf | input | 1 | Timer 1 event |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| ser_rx_done | input | 1 | Serial receive flag |
| ser_tx_done | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the winner |
| ext_flag | output | 2 | Edge detect flags |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |

## Verification
Request and vector outputs have zero latency. After inputs are driven on a falling clock edge, they are checked two nanoseconds later, in the same cycle. Edge flags and in-service bits are due one rising edge after the falling pin or the acknowledge/return pulse. The bench drives the stimulus and then waits exactly one rising edge before checking those, and it also checks the value before the edge where a lag is expected. Selection is swept over every request pattern, crossed with every priority mask and with every enable mask. The expected winner is computed by a separate descending scan.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC       = 6;
  localparam int NEXT       = 2;
  localparam int IDX_W      = $clog2(NSRC);
  localparam int VEC_W      = 8;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;

  typedef enum logic [IDX_W-1:0] {
    SLOT_EXT0 = 3'd0,
    SLOT_TMR0 = 3'd1,
    SLOT_EXT1 = 3'd2,
    SLOT_TMR1 = 3'd3,
    SLOT_SER  = 3'd4,
    SLOT_TMR2 = 3'd5
  } slot_e;

  // Lowest set index of a request mask (0 if empty).
  function automatic logic [IDX_W-1:0] lowest_index(input logic [NSRC-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Vector address for a slot.
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx));
  endfunction

  // Slot used by external input k.
  function automatic int ext_slot(input int k);
    return 2 * k;
  endfunction
endpackage

// File: rtl/irqv_edge_detect.sv
module irqv_edge_detect #(
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] pin_n,
  input  logic [NEXT-1:0] edge_mode,
  input  logic [NEXT-1:0] clr,
  output logic [NEXT-1:0] req,
  output logic [NEXT-1:0] flag,
  output logic [NEXT-1:0] fall
);
  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    logic pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= pin_n[k];
    end

    assign fall[k] = pin_q & ~pin_n[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flag[k] <= 1'b0;
      else if (!edge_mode[k]) flag[k] <= 1'b0;
      else if (fall[k])       flag[k] <= 1'b1;
      else if (clr[k])        flag[k] <= 1'b0;
    end

    assign req[k] = edge_mode[k] ? flag[k] : ~pin_n[k];
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  pri,
  output logic             any_hi,
  output logic             any_lo,
  output logic [IDX_W-1:0] idx_hi,
  output logic [IDX_W-1:0] idx_lo
);
  logic [NSRC-1:0] hi_mask, lo_mask;

  assign hi_mask = req & pri;
  assign lo_mask = req & ~pri;
  assign any_hi  = |hi_mask;
  assign any_lo  = |lo_mask;
  assign idx_hi  = lowest_index(hi_mask);
  assign idx_lo  = lowest_index(lo_mask);
endmodule

// File: rtl/irqv_svc_track.sv
module irqv_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic grant_hi,
  input  logic ret,
  output logic svc_hi,
  output logic svc_lo
);
  logic nxt_hi, nxt_lo;

  always_comb begin
    nxt_hi = svc_hi;
    nxt_lo = svc_lo;
    if (ret) begin
      if (svc_hi) nxt_hi = 1'b0;
      else        nxt_lo = 1'b0;
    end
    if (grant) begin
      if (grant_hi) nxt_hi = 1'b1;
      else          nxt_lo = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else begin
      svc_hi <= nxt_hi;
      svc_lo <= nxt_lo;
    end
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  pri_sel,
  input  logic [NEXT-1:0]  ext_pin_n,
  input  logic [NEXT-1:0]  ext_edge_mode,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             tmr2_ovf,
  input  logic             tmr2_ext,
  input  logic             ser_rx_done,
  input  logic             ser_tx_done,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [NEXT-1:0]  ext_flag,
  output logic             svc_hi,
  output logic             svc_lo
);
  logic [NEXT-1:0]  ext_req, ext_clr, ext_fall;
  logic [NSRC-1:0]  raw_req, live_req;
  logic             any_hi, any_lo, hi_ok, lo_ok;
  logic [IDX_W-1:0] idx_hi, idx_lo, win_idx;
  logic             grant;

  irqv_edge_detect #(.NEXT(NEXT)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n), .edge_mode(ext_edge_mode),
    .clr(ext_clr), .req(ext_req), .flag(ext_flag), .fall(ext_fall)
  );

  always_comb begin
    raw_req            = '0;
    raw_req[SLOT_EXT0] = ext_req[0];
    raw_req[SLOT_TMR0] = tmr0_ovf;
    raw_req[SLOT_EXT1] = ext_req[1];
    raw_req[SLOT_TMR1] = tmr1_ovf;
    raw_req[SLOT_SER]  = ser_rx_done | ser_tx_done;
    raw_req[SLOT_TMR2] = tmr2_ovf | tmr2_ext;
  end

  assign live_req = glb_en ? (raw_req & src_en) : '0;

  irqv_arbiter u_arb (
    .req(live_req), .pri(pri_sel), .any_hi(any_hi), .any_lo(any_lo),
    .idx_hi(idx_hi), .idx_lo(idx_lo)
  );

  assign hi_ok   = any_hi & ~svc_hi;
  assign lo_ok   = any_lo & ~svc_hi & ~svc_lo;
  assign irq_req = hi_ok | lo_ok;
  assign win_idx = hi_ok ? idx_hi : idx_lo;
  assign irq_vec = irq_req ? vec_of(win_idx) : '0;
  assign grant   = irq_ack & irq_req;

  for (genvar k = 0; k < NEXT; k++) begin : g_clr
    assign ext_clr[k] = grant && (win_idx == IDX_W'(ext_slot(k)));
  end

  irqv_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_hi(hi_ok),
    .ret(irq_ret), .svc_hi(svc_hi), .svc_lo(svc_lo)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  pri_sel,
  input logic             glb_en,
  input logic [NEXT-1:0]  ext_edge_mode,
  input logic [NEXT-1:0]  ext_fall,
  input logic             irq_ack,
  input logic             irq_ret,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [NEXT-1:0]  ext_flag,
  input logic             svc_hi,
  input logic             svc_lo
);
  logic [VEC_W-1:0] vec_slot;
  assign vec_slot = (irq_vec - VEC_W'(VEC_BASE)) / VEC_W'(VEC_STRIDE);

  assert_vec_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= vec_of(IDX_W'(NSRC - 1))));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);

  assert_high_blocks_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |-> !irq_req);

  assert_low_passes_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_lo && irq_req) |-> ((pri_sel & (NSRC'(1) << vec_slot)) != '0));

  assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_ret) |=> (svc_hi || svc_lo));

  assert_ret_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && svc_hi && !irq_ack) |=> !svc_hi);

  assert_edge_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == vec_of(IDX_W'(ext_slot(0))) && !ext_fall[0])
      |=> !ext_flag[0]);

  assert_level_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_edge_mode[1] |=> !ext_flag[1]);
endmodule

bind irqv_ctrl irqv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pri_sel(pri_sel), .glb_en(glb_en),
  .ext_edge_mode(ext_edge_mode), .ext_fall(ext_fall), .irq_ack(irq_ack),
  .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
  .ext_flag(ext_flag), .svc_hi(svc_hi), .svc_lo(svc_lo)
);

// File: tb/tb_irqv_ctrl.sv
`timescale 1ns/1ps
module tb_irqv_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_en, pri_sel;
  logic       glb_en;
  logic [1:0] ext_pin_n, ext_edge_mode;
  logic       tmr0_ovf, tmr1_ovf, tmr2_ovf, tmr2_ext, ser_rx_done, ser_tx_done;
  logic       irq_ack, irq_ret;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic [1:0] ext_flag;
  logic       svc_hi, svc_lo;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .glb_en(glb_en), .pri_sel(pri_sel),
    .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode), .tmr0_ovf(tmr0_ovf),
    .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext),
    .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec), .ext_flag(ext_flag),
    .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One rising edge, then back to the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected {req, vec}: descending scan so the last hit is the lowest slot.
  function automatic logic [8:0] model(input logic [5:0] r, input logic [5:0] en,
                                       input logic g, input logic [5:0] pri,
                                       input logic shi, input logic slo);
    logic [5:0] e;
    int pick;
    e = g ? (r & en) : 6'd0;
    pick = -1;
    if (!shi) for (int i = 5; i >= 0; i--) if (e[i] && pri[i]) pick = i;
    if (pick < 0 && !shi && !slo) for (int i = 5; i >= 0; i--) if (e[i] && !pri[i]) pick = i;
    return (pick < 0) ? 9'h000 : {1'b1, 8'(3 + 8 * pick)};
  endfunction

  task automatic drive_req(input logic [5:0] r, input bit alt);
    ext_pin_n[0] = ~r[0];
    tmr0_ovf     = r[1];
    ext_pin_n[1] = ~r[2];
    tmr1_ovf     = r[3];
    ser_rx_done  = r[4] & alt;
    ser_tx_done  = r[4] & ~alt;
    tmr2_ovf     = r[5] & ~alt;
    tmr2_ext     = r[5] & alt;
  endtask

  task automatic sweep_one(input logic [5:0] r, input logic [5:0] en, input logic g,
                           input logic [5:0] pri, input bit alt, input string tag);
    logic [8:0] e;
    @(negedge clk);
    src_en = en; glb_en = g; pri_sel = pri;
    drive_req(r, alt);
    #2;
    e = model(r, en, g, pri, 1'b0, 1'b0);
    chk(tag, {23'd0, irq_req, irq_vec}, {23'd0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_en = '1; glb_en = 1'b1; pri_sel = '0;
    ext_pin_n = '1; ext_edge_mode = '0;
    tmr0_ovf = 0; tmr1_ovf = 0; tmr2_ovf = 0; tmr2_ext = 0;
    ser_rx_done = 0; ser_tx_done = 0; irq_ack = 0; irq_ret = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_vec", irq_vec, 0);
    chk("R1 ext_flag", ext_flag, 0);
    chk("R1 svc", {svc_hi, svc_lo}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R4 R5 R11: every request pattern against every priority mask.
    for (int p = 0; p < 64; p++)
      for (int r = 0; r < 64; r++)
        sweep_one(6'(r), 6'h3F, 1'b1, 6'(p), bit'((p + r) & 1), "R4 R2 R5 R11 priority sweep");
    // R3: every enable mask against every request pattern.
    for (int en = 0; en < 64; en++)
      for (int r = 0; r < 64; r++)
        sweep_one(6'(r), 6'(en), 1'b1, 6'h2A, bit'(r & 1), "R3 enable sweep");
    for (int r = 0; r < 64; r++)
      sweep_one(6'(r), 6'h3F, 1'b0, 6'h15, bit'(r & 1), "R3 global gate");

    @(negedge clk);
    src_en = '1; glb_en = 1; pri_sel = '0;
    drive_req(6'd0, 1'b0);
    #2;
    chk("R5 serial rx alone", irq_vec, 0);
    ser_rx_done = 1; #2; chk("R5 serial rx", irq_vec, 8'h23);
    ser_rx_done = 0; tmr2_ext = 1; #2; chk("R5 timer2 ext", irq_vec, 8'h2B);
    tmr2_ext = 0; tmr2_ovf = 1; #2; chk("R5 timer2 ovf", irq_vec, 8'h2B);
    tmr2_ovf = 0;

    // R8: ack with nothing pending is ignored.
    irq_ack = 1; step(); irq_ack = 0; #2;
    chk("R8 ack ignored svc", {svc_hi, svc_lo}, 0);
    tmr1_ovf = 1; #2;
    chk("R8 low request shown", {irq_req, irq_vec}, {1'b1, 8'h1B});
    irq_ack = 1; step(); irq_ack = 0; #2;
    chk("R8 low in service", {svc_hi, svc_lo}, 2'b01);
    chk("R9 low blocks low", irq_req, 0);
    pri_sel[4] = 1; ser_tx_done = 1; #2;
    chk("R9 high preempts low", {irq_req, irq_vec}, {1'b1, 8'h23});
    irq_ack = 1; step(); irq_ack = 0; #2;
    chk("R8 high in service", {svc_hi, svc_lo}, 2'b11);
    chk("R9 high blocks all", irq_req, 0);
    irq_ret = 1; step(); irq_ret = 0; #2;
    chk("R10 ret closes high", {svc_hi, svc_lo}, 2'b01);
    chk("R10 held high reappears", {irq_req, irq_vec}, {1'b1, 8'h23});
    ser_tx_done = 0; #2;
    chk("R11 level drop", irq_req, 0);
    irq_ret = 1; step(); irq_ret = 0; #2;
    chk("R10 ret closes low", {svc_hi, svc_lo}, 2'b00);
    chk("R10 low reappears", {irq_req, irq_vec}, {1'b1, 8'h1B});
    tmr1_ovf = 0; pri_sel = '0;

    // R6: edge mode on external 0.
    ext_edge_mode[0] = 1; step();
    ext_pin_n[0] = 0; #2;
    chk("R6 no flag before edge", {ext_flag[0], irq_req}, 2'b00);
    step(); #2;
    chk("R6 flag set", ext_flag[0], 1);
    chk("R6 vector", {irq_req, irq_vec}, {1'b1, 8'h03});
    ext_pin_n[0] = 1; step(); #2;
    chk("R6 flag holds", {ext_flag[0], irq_req}, 2'b11);
    irq_ack = 1; step(); irq_ack = 0; #2;
    chk("R6 ack clears flag", ext_flag[0], 0);
    chk("R8 edge in service", svc_lo, 1);
    irq_ret = 1; step(); irq_ret = 0; #2;
    chk("R6 nothing pending", irq_req, 0);
    ext_pin_n[0] = 0; step(); #2;
    chk("R6 second edge", ext_flag[0], 1);
    irq_ack = 1; step(); irq_ack = 0; step(); #2;
    chk("R6 held low no retrigger", ext_flag[0], 0);
    irq_ret = 1; step(); irq_ret = 0;
    ext_pin_n[0] = 1; step();
    ext_pin_n[0] = 0; step(); ext_pin_n[0] = 1; #2;
    chk("R6 third edge", ext_flag[0], 1);
    ext_edge_mode[0] = 0; step(); #2;
    chk("R7 mode switch clears flag", {ext_flag[0], irq_req}, 2'b00);

    // R7: level mode on external 1.
    ext_pin_n[1] = 0; #2;
    chk("R7 level request", {irq_req, irq_vec}, {1'b1, 8'h13});
    step(); #2;
    chk("R7 no flag", ext_flag[1], 0);
    ext_pin_n[1] = 1; #2;
    chk("R7 level release", irq_req, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule